// File: doc/BRIEF.md
# Dual-Port Word Memory with Selectable Lane Enables

This block is a synchronous memory with two fully independent ports, A and B, sharing one storage array of 72-bit words. Each port presents an address, a write strobe, a 9-bit lane-enable vector and a 72-bit write word on every clock. Whether or not it writes, each port returns the full stored word at its address one clock later.

The low 64 bits of a word are eight data bytes. The top 8 bits are extra bits that may hold parity or plain data. A per-port parameter chooses how the enable vector covers those top bits. In joined mode each of the eight low enables also carries one top bit alongside its byte. In split mode a ninth enable covers the whole top byte on its own. The two ports may use different modes on the same array.

When both ports write one address in the same cycle, the bits are resolved lane by lane. Port A wins wherever both ports enable a bit. A bit enabled by only one port takes that port's data.

Top module: `bwe_dpram`

## Requirements
- R1: In joined mode, enable bit i (0 to 7) writes bits [8i+7:8i] of the word together with bit 64+i, and nothing else.
- R2: In joined mode, enable bit 8 has no effect: a write whose only asserted enable is bit 8 leaves the stored word unchanged.
- R3: In split mode, enable bit i (0 to 7) writes only bits [8i+7:8i] and leaves bits 71:64 unchanged.
- R4: In split mode, enable bit 8 writes bits 71:64 and no data byte.
- R5: A port changes the array only on a rising clock edge with its write strobe high. Bits not covered by an asserted enable keep their stored value.
- R6: Each port's read output shows the full 72-bit word at the address presented at the previous rising edge.
- R7: Reads are read-first. A port that reads an address being written in the same cycle, by itself or by the other port, sees the contents from before that write.
- R8: When both ports write the same address in one cycle, port A's data is stored in every bit both ports enable. Bits enabled by one port only take that port's data, and bits enabled by neither keep their value.
- R9: While the synchronous active-high reset is high, both read outputs become zero on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the read outputs |
| a_we | input | 1 | Port A write strobe |
| a_addr | input | log2(DEPTH) | Port A word address |
| a_bwe | input | 9 | Port A lane enables (bit 8 used in split mode only) |
| a_din | input | 72 | Port A write word |
| a_dout | output | 72 | Port A registered read word |
| b_we | input | 1 | Port B write strobe |
| b_addr | input | log2(DEPTH) | Port B word address |
| b_bwe | input | 9 | Port B lane enables (bit 8 used in split mode only) |
| b_din | input | 72 | Port B write word |
| b_dout | output | 72 | Port B registered read word |

## Verification
Two writes from both ports can land on one address in the same cycle. A read can also coincide with a write to the address it is reading. The bench provokes both cases with directed collisions: one has overlapping and disjoint lanes across a joined-mode port A and a split-mode port B, and one is a same-cycle write and read. It then runs a long random phase with addresses confined to eight words, so that collisions and read-during-write occur often. A behavioural model applies port B's masked write and then port A's, which yields A priority on shared bits. It takes each port's expected read value from before either write, and every clock both outputs are compared against it.

// File: rtl/bwe_dpram_pkg.sv
package bwe_dpram_pkg;

    localparam int LANE_W  = 8;
    localparam int LANES   = 8;
    localparam int DATA_W  = LANE_W * LANES;
    localparam int EXTRA_W = 8;
    localparam int WORD_W  = DATA_W + EXTRA_W;
    localparam int EN_W    = LANES + 1;

    typedef enum logic {
        LANE_JOINED = 1'b0,
        LANE_SPLIT  = 1'b1
    } lane_mode_e;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [EN_W-1:0]   en_t;

    typedef struct packed {
        logic  we;
        word_t mask;
        word_t data;
    } wr_req_t;

    function automatic word_t lane_mask(lane_mode_e mode, en_t en);
        word_t k;
        k = '0;
        for (int i = 0; i < LANES; i++) begin
            k[LANE_W*i +: LANE_W] = {LANE_W{en[i]}};
            k[DATA_W + i] = (mode == LANE_JOINED) ? en[i] : en[LANES];
        end
        return k;
    endfunction

endpackage

// File: rtl/bwe_lane_decode.sv
module bwe_lane_decode
    import bwe_dpram_pkg::*;
#(
    parameter lane_mode_e MODE = LANE_JOINED
) (
    input  logic    we,
    input  en_t     bwe,
    input  word_t   din,
    output wr_req_t req
);

    word_t mask;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign mask[LANE_W*g +: LANE_W] = {LANE_W{bwe[g]}};
        if (MODE == LANE_JOINED) begin : g_joined
            assign mask[DATA_W + g] = bwe[g];
        end else begin : g_split
            assign mask[DATA_W + g] = bwe[LANES];
        end
    end

    assign req.we   = we;
    assign req.mask = mask;
    assign req.data = din;

endmodule

// File: rtl/bwe_collision_merge.sv
module bwe_collision_merge
    import bwe_dpram_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  wr_req_t           in_a,
    input  wr_req_t           in_b,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    output wr_req_t           out_a,
    output wr_req_t           out_b
);

    logic  clash;
    word_t b_only;

    assign clash  = in_a.we && in_b.we && (addr_a == addr_b);
    assign b_only = in_b.mask & ~in_a.mask;

    always_comb begin
        out_a = in_a;
        out_b = in_b;
        if (clash) begin
            out_a.mask = in_a.mask | in_b.mask;
            out_a.data = (in_a.data & in_a.mask) | (in_b.data & b_only);
            out_b.we   = 1'b0;
        end
    end

endmodule

// File: rtl/bwe_storage.sv
module bwe_storage
    import bwe_dpram_pkg::*;
#(
    parameter int DEPTH  = 4096,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr_a,
    input  wr_req_t           wr_b,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    output word_t             rd_a,
    output word_t             rd_b
);

    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_a.we) begin
            mem[addr_a] <= (mem[addr_a] & ~wr_a.mask) | (wr_a.data & wr_a.mask);
        end
        if (wr_b.we) begin
            mem[addr_b] <= (mem[addr_b] & ~wr_b.mask) | (wr_b.data & wr_b.mask);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_a <= '0;
            rd_b <= '0;
        end else begin
            rd_a <= mem[addr_a];
            rd_b <= mem[addr_b];
        end
    end

endmodule

// File: rtl/bwe_dpram.sv
module bwe_dpram
    import bwe_dpram_pkg::*;
#(
    parameter int         DEPTH  = 4096,
    parameter lane_mode_e MODE_A = LANE_JOINED,
    parameter lane_mode_e MODE_B = LANE_SPLIT,
    localparam int        ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [EN_W-1:0]   a_bwe,
    input  logic [WORD_W-1:0] a_din,
    output logic [WORD_W-1:0] a_dout,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [EN_W-1:0]   b_bwe,
    input  logic [WORD_W-1:0] b_din,
    output logic [WORD_W-1:0] b_dout
);

    wr_req_t req_a, req_b;
    wr_req_t fin_a, fin_b;

    bwe_lane_decode #(.MODE(MODE_A)) u_dec_a (
        .we(a_we), .bwe(a_bwe), .din(a_din), .req(req_a)
    );

    bwe_lane_decode #(.MODE(MODE_B)) u_dec_b (
        .we(b_we), .bwe(b_bwe), .din(b_din), .req(req_b)
    );

    bwe_collision_merge #(.ADDR_W(ADDR_W)) u_merge (
        .in_a(req_a), .in_b(req_b), .addr_a(a_addr), .addr_b(b_addr),
        .out_a(fin_a), .out_b(fin_b)
    );

    bwe_storage #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst(rst), .wr_a(fin_a), .wr_b(fin_b),
        .addr_a(a_addr), .addr_b(b_addr), .rd_a(a_dout), .rd_b(b_dout)
    );

endmodule

// File: rtl/bwe_dpram_checker.sv
module bwe_dpram_checker
    import bwe_dpram_pkg::*;
#(
    parameter int         DEPTH  = 4096,
    parameter lane_mode_e MODE_A = LANE_JOINED,
    parameter lane_mode_e MODE_B = LANE_SPLIT,
    localparam int        ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              a_we,
    input logic [ADDR_W-1:0] a_addr,
    input logic [EN_W-1:0]   a_bwe,
    input logic [WORD_W-1:0] a_din,
    input logic [WORD_W-1:0] a_dout,
    input logic              b_we,
    input logic [ADDR_W-1:0] b_addr,
    input logic [EN_W-1:0]   b_bwe,
    input logic [WORD_W-1:0] b_din,
    input logic [WORD_W-1:0] b_dout
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (a_dout == '0 && b_dout == '0)); // R9

    AST_SAME_ADDR_AGREE: assert property (@(posedge clk) disable iff (rst)
        (a_addr == b_addr) |=> (a_dout === b_dout)); // R7

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (a_addr == $past(a_addr) && !$past(a_we) && !$past(b_we) && !$past(rst))
        |=> $stable(a_dout)); // R6

    AST_COLLISION_A_WINS: assert property (@(posedge clk) disable iff (rst)
        ($past(a_we, 2) && $past(b_we, 2) && $past(a_addr, 2) == $past(b_addr, 2)
         && $past(a_addr) == $past(a_addr, 2) && !$past(rst))
        |-> ((a_dout & lane_mask(MODE_A, $past(a_bwe, 2)))
             == ($past(a_din, 2) & lane_mask(MODE_A, $past(a_bwe, 2))))); // R8

endmodule

bind bwe_dpram bwe_dpram_checker #(
    .DEPTH(DEPTH), .MODE_A(MODE_A), .MODE_B(MODE_B)
) u_chk (.*);

// File: tb/bwe_dpram_test.sv
module bwe_dpram_test;
    import bwe_dpram_pkg::*;

    localparam int D  = 64;
    localparam int AW = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        a_we = 1'b0, b_we = 1'b0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [8:0]  a_bwe = '0, b_bwe = '0;
    logic [71:0] a_din = '0, b_din = '0;
    logic [71:0] a_dout, b_dout;

    int checks = 0;
    int errors = 0;
    logic [71:0] model [D];

    always #4 clk = ~clk;

    bwe_dpram #(.DEPTH(D), .MODE_A(LANE_JOINED), .MODE_B(LANE_SPLIT)) uut (
        .clk(clk), .rst(rst),
        .a_we(a_we), .a_addr(a_addr), .a_bwe(a_bwe), .a_din(a_din), .a_dout(a_dout),
        .b_we(b_we), .b_addr(b_addr), .b_bwe(b_bwe), .b_din(b_din), .b_dout(b_dout)
    );

    function automatic logic [71:0] cover_bits(bit joined, logic [8:0] en);
        logic [71:0] m;
        for (int i = 0; i < 72; i++) begin
            if (i < 64) m[i] = en[i / 8];
            else if (joined) m[i] = en[i - 64];
            else m[i] = en[8];
        end
        return m;
    endfunction

    task automatic check(string tag, string port, logic [71:0] act, logic [71:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s port %s: actual %h expected %h", tag, port, act, exp);
        end
    endtask

    task automatic step(string tag,
                        logic wa, logic [AW-1:0] aa, logic [8:0] ea, logic [71:0] da,
                        logic wb, logic [AW-1:0] ab, logic [8:0] eb, logic [71:0] db);
        logic [71:0] exp_a, exp_b, ma, mb;
        a_we = wa; a_addr = aa; a_bwe = ea; a_din = da;
        b_we = wb; b_addr = ab; b_bwe = eb; b_din = db;
        exp_a = model[aa];
        exp_b = model[ab];
        ma = cover_bits(1'b1, ea);
        mb = cover_bits(1'b0, eb);
        if (wb) model[ab] = (model[ab] & ~mb) | (db & mb);
        if (wa) model[aa] = (model[aa] & ~ma) | (da & ma);
        @(posedge clk);
        @(negedge clk);
        check(tag, "A", a_dout, exp_a);
        check(tag, "B", b_dout, exp_b);
    endtask

    task automatic rd(string tag, logic [AW-1:0] aa, logic [AW-1:0] ab);
        step(tag, 1'b0, aa, 9'h0, 72'h0, 1'b0, ab, 9'h0, 72'h0);
    endtask

    localparam logic [71:0] ONES = {72{1'b1}};

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [95:0] r1, r2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9", "A", a_dout, 72'h0);
        check("R9", "B", b_dout, 72'h0);
        rst = 1'b0;

        for (int i = 0; i < D; i++) begin
            a_we = 1'b1; a_addr = AW'(i); a_bwe = 9'h0FF; a_din = '0;
            model[i] = '0;
            @(posedge clk);
            @(negedge clk);
        end
        a_we = 1'b0;

        // R1: joined-mode lane 2 writes byte 2 plus bit 66
        step("R1", 1'b1, 6'd1, 9'h004, ONES, 1'b0, 6'd0, 9'h0, 72'h0);
        rd("R1", 6'd1, 6'd1);
        check("R1", "A-lit", a_dout, 72'h04_0000_0000_00FF_0000);
        // R2: joined-mode enable 8 ignored
        step("R2", 1'b1, 6'd2, 9'h100, ONES, 1'b0, 6'd0, 9'h0, 72'h0);
        rd("R2", 6'd2, 6'd2);
        check("R2", "A-lit", a_dout, 72'h0);
        // R3: split-mode lane 4 writes byte 4 only
        step("R3", 1'b0, 6'd0, 9'h0, 72'h0, 1'b1, 6'd3, 9'h010, ONES);
        rd("R3", 6'd3, 6'd3);
        check("R3", "B-lit", b_dout, 72'h00_0000_00FF_0000_0000);
        // R4: split-mode enable 8 writes top byte only
        step("R4", 1'b0, 6'd0, 9'h0, 72'h0, 1'b1, 6'd4, 9'h100, ONES);
        rd("R4", 6'd4, 6'd4);
        check("R4", "B-lit", b_dout, 72'hFF_0000_0000_0000_0000);
        // R5: strobe low with all enables writes nothing
        step("R5", 1'b0, 6'd5, 9'h1FF, ONES, 1'b0, 6'd5, 9'h1FF, ONES);
        rd("R5", 6'd5, 6'd5);
        check("R5", "A-lit", a_dout, 72'h0);
        // R6: full word read one cycle later
        step("R6", 1'b1, 6'd7, 9'h0FF, 72'hA1_2345_6789_ABCD_EF01, 1'b0, 6'd0, 9'h0, 72'h0);
        rd("R6", 6'd7, 6'd7);
        check("R6", "A-lit", a_dout, 72'hA1_2345_6789_ABCD_EF01);
        // R7: read during write returns old contents on both ports
        step("R7", 1'b1, 6'd7, 9'h0FF, ONES, 1'b0, 6'd7, 9'h0, 72'h0);
        check("R7", "A-lit", a_dout, 72'hA1_2345_6789_ABCD_EF01);
        rd("R7", 6'd7, 6'd7);
        // R8: collision, A joined lanes 0-3, B split lanes 3,4 and top
        step("R8", 1'b1, 6'd8, 9'h00F, {72{1'b1}} & 72'hA5_A5A5_A5A5_A5A5_A5A5,
                   1'b1, 6'd8, 9'h118, 72'h5A_5A5A_5A5A_5A5A_5A5A);
        rd("R8", 6'd8, 6'd8);
        check("R8", "A-lit", a_dout, 72'h55_0000_005A_A5A5_A5A5);

        for (int n = 0; n < 3000; n++) begin
            logic wa, wb;
            logic [AW-1:0] aa, ab;
            r1 = {$urandom(), $urandom(), $urandom()};
            r2 = {$urandom(), $urandom(), $urandom()};
            wa = $urandom_range(0, 1) == 1;
            wb = $urandom_range(0, 1) == 1;
            aa = AW'($urandom_range(0, 7));
            ab = AW'($urandom_range(0, 7));
            step((wa && wb && aa == ab) ? "R8" : "R6",
                 wa, aa, 9'($urandom()), r1[71:0],
                 wb, ab, 9'($urandom()), r2[71:0]);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule